// File: doc/BRIEF.md
# Priority Interrupt Acceptance Controller

This block sits beside a processor core and decides which pending interrupt, if any, the core should take. It watches a non-maskable interrupt (NMI) input, a debug-break input and a set of maskable request lines. Each maskable line carries its own 4-bit urgency level in the range 1 to 15. The block selects the single most urgent pending source and compares its level against the core's 4-bit mask. When that level is higher than the mask, it drives an active-low request output.

When a request is taken, the block runs the exception-entry steps by itself through a memory port. It first pushes the status word and the current program counter onto a pre-decremented stack. It then raises the mask to the level of the taken source and reads the handler address from a vector table. Finally it issues a one-cycle branch to that address. The core writes the mask through a plain control input while no entry is in progress.

The memory port is a valid/ready request channel. Once `mem_valid` is high, the address, the write flag and the write data stay constant until a cycle in which `mem_ready` is also high. A transfer completes only in that cycle. For a read, `mem_rdata` is taken in the same cycle. The block holds no limit on how long `mem_ready` may stay low.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset the mask is 15, `busy` is 0, `branch_valid` is 0 and `irq_req_n` is 1.
- R2: A maskable request of level L (1..15) drives `irq_req_n` low and is taken only when L > mask. A level of 0 never requests.
- R3: The winner is chosen in this order: NMI, then debug break, then the highest maskable level. Among equal levels, the lowest source index wins.
- R4: A debug break behaves like a level-15 request. It is taken only when the mask is 14 or lower, and taking it loads 15 into the mask.
- R5: NMI is taken whatever the mask is, and taking it loads 15 into the mask.
- R6: The entry steps run in this order:
  - Write the status word `{status_in[31:4], old mask}` to `sp_in-4`.
  - Write `pc_in` to `sp_in-8`.
  - Load the new mask.
  - Read the word at `VEC_BASE + 4*vector`.
  - Pulse `branch_valid` for one cycle with `branch_target` equal to the word read and `sp_new` equal to `sp_in-8`.
  
  The vector numbers are: NMI 11, break 12, and source i gets 16+i.
- R7: An edge-triggered source (NMI, and maskable sources whose `EDGE_SRC` bit is 1) is latched on a rising edge of its input. It stays pending, even while masked, until it is taken, and taking it clears the latch.
- R8: After an edge-triggered source is taken, `irq_req_n` returns high in the next cycle. It stays low instead if another pending source is still above the mask.
- R9: While `busy` is 1 no new source is taken. A source that arrives during an entry is taken after the branch.
- R10: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R11: A level-triggered source (break, and maskable sources whose `EDGE_SRC` bit is 0) is not latched. If it is removed before being taken, it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nmi_in | input | 1 | Non-maskable request, rising-edge triggered |
| brk_in | input | 1 | Debug break request, level triggered |
| src_req | input | NSRC | Maskable request lines |
| src_lvl | input | 4*NSRC | Level of each maskable line, 4 bits per line, line i at [4i+3:4i] |
| status_in | input | 32 | Status word of the core; bits 3:0 are replaced by the mask when stacked |
| pc_in | input | 32 | Current program counter |
| sp_in | input | 32 | Current stack pointer |
| mask_wr_en | input | 1 | Loads `mask_wr_val` into the mask when idle |
| mask_wr_val | input | 4 | New mask value |
| irq_req_n | output | 1 | Active-low request to the core |
| mask_lvl | output | 4 | Current mask |
| busy | output | 1 | Entry in progress |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the handshake cycle |
| branch_valid | output | 1 | One-cycle branch strobe |
| branch_target | output | 32 | Handler address |
| sp_new | output | 32 | Stack pointer after the two pushes |

## Verification
The case that is hardest to reach from the ports is a second pending source that keeps the request low just after another one has been taken. To get there, the bench latches two edge-triggered sources in the same cycle and then watches `irq_req_n` in the cycle after the first one is taken. It also pulses NMI while an entry is under way, to show that the NMI waits for the branch. Underneath these cases, every mask value is swept against every request level, so each pairing completes or refuses a full entry while the memory ready line stalls on a fixed pattern.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int LVL_W = 4;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_SR, ST_PUSH_PC, ST_LOAD, ST_FETCH, ST_BRANCH
  } seq_st_t;
endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
  parameter bit EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic clr,
  output logic pend
);
  generate
    if (EDGE) begin : g_edge
      logic req_q, pend_q, rise;
      assign rise = req_in & ~req_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          req_q  <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          req_q  <= req_in;
          pend_q <= (pend_q & ~clr) | rise;
        end
      end
      assign pend = pend_q;
      // R7: a taken edge source is cleared unless a fresh edge arrives
      p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !rise) |=> !pend) else $error("p_clear_r7");
    end else begin : g_level
      wire unused_clr = clr;
      assign pend = req_in;
    end
  endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NSRC = 4,
  localparam int IDW = $clog2(NSRC + 2)
) (
  input  logic                          nmi_p,
  input  logic                          brk_p,
  input  logic [NSRC-1:0]               src_p,
  input  logic [NSRC*irq_accept_pkg::LVL_W-1:0] src_lvl,
  output logic                          win_valid,
  output logic [4:0]                    win_lvl,
  output logic [IDW-1:0]                win_id
);
  import irq_accept_pkg::*;
  always_comb begin
    win_lvl = 5'd0;
    win_id  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_p[i] && ({1'b0, src_lvl[i*LVL_W +: LVL_W]} > win_lvl)) begin
        win_lvl = {1'b0, src_lvl[i*LVL_W +: LVL_W]};
        win_id  = IDW'(i + 2);
      end
    end
    if (brk_p) begin
      win_lvl = 5'd15;
      win_id  = IDW'(1);
    end
    if (nmi_p) begin
      win_lvl = 5'd16;
      win_id  = '0;
    end
    win_valid = (win_lvl != 5'd0);
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int          NSRC     = 4,
  parameter logic [31:0] VEC_BASE = 32'h0,
  parameter int          VEC_NMI  = 11,
  parameter int          VEC_BRK  = 12,
  parameter int          VEC_SRC0 = 16,
  localparam int         IDW      = $clog2(NSRC + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic [IDW-1:0] win_id,
  input  logic [4:0]     win_lvl,
  input  logic [31:0]    status_in,
  input  logic [31:0]    pc_in,
  input  logic [31:0]    sp_in,
  input  logic           mask_wr_en,
  input  logic [3:0]     mask_wr_val,
  output logic [3:0]     mask_q,
  output logic           busy,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic           mem_we,
  output logic [31:0]    mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata,
  output logic           branch_valid,
  output logic [31:0]    branch_target,
  output logic [31:0]    sp_new
);
  import irq_accept_pkg::*;
  seq_st_t     st;
  logic [3:0]  acc_lvl;
  logic [31:0] vec_addr, sr_snap, pc_snap, sp_snap, tgt_q, vec_num;
  wire [3:0]   unused_status = status_in[3:0];

  always_comb begin
    if (win_id == '0)          vec_num = 32'(VEC_NMI);
    else if (win_id == IDW'(1)) vec_num = 32'(VEC_BRK);
    else                        vec_num = 32'(VEC_SRC0) + 32'(win_id) - 32'd2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      mask_q   <= 4'hF;
      acc_lvl  <= 4'h0;
      vec_addr <= '0;
      sr_snap  <= '0;
      pc_snap  <= '0;
      sp_snap  <= '0;
      tgt_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            acc_lvl  <= (win_id == '0) ? 4'hF : win_lvl[3:0];
            vec_addr <= VEC_BASE + (vec_num << 2);
            sr_snap  <= {status_in[31:4], mask_q};
            pc_snap  <= pc_in;
            sp_snap  <= sp_in;
            st       <= ST_PUSH_SR;
          end else if (mask_wr_en) begin
            mask_q <= mask_wr_val;
          end
        end
        ST_PUSH_SR: if (mem_ready) st <= ST_PUSH_PC;
        ST_PUSH_PC: if (mem_ready) st <= ST_LOAD;
        ST_LOAD: begin
          mask_q <= acc_lvl;
          st     <= ST_FETCH;
        end
        ST_FETCH: if (mem_ready) begin
          tgt_q <= mem_rdata;
          st    <= ST_BRANCH;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_valid = (st == ST_PUSH_SR) || (st == ST_PUSH_PC) || (st == ST_FETCH);
    mem_we    = (st == ST_PUSH_SR) || (st == ST_PUSH_PC);
    mem_wdata = (st == ST_PUSH_SR) ? sr_snap : ((st == ST_PUSH_PC) ? pc_snap : 32'h0);
    case (st)
      ST_PUSH_SR: mem_addr = sp_snap - 32'd4;
      ST_PUSH_PC: mem_addr = sp_snap - 32'd8;
      ST_FETCH:   mem_addr = vec_addr;
      default:    mem_addr = 32'h0;
    endcase
  end

  assign busy          = (st != ST_IDLE);
  assign branch_valid  = (st == ST_BRANCH);
  assign branch_target = tgt_q;
  assign sp_new        = sp_snap - 32'd8;

  // R10: a stalled memory request keeps its content
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata))) else $error("p_req_hold_r10");
  // R6: the branch strobe lasts one cycle and ends the entry
  p_branch_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    branch_valid |=> (!branch_valid && !busy)) else $error("p_branch_pulse_r6");
  // R6: the new mask is in place before the vector is fetched
  p_mask_loaded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FETCH) |-> (mask_q == acc_lvl)) else $error("p_mask_loaded_r6");
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl #(
  parameter int              NSRC     = 4,
  parameter logic [NSRC-1:0] EDGE_SRC = 4'b0011,
  parameter logic [31:0]     VEC_BASE = 32'h0,
  parameter int              VEC_NMI  = 11,
  parameter int              VEC_BRK  = 12,
  parameter int              VEC_SRC0 = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_in,
  input  logic              brk_in,
  input  logic [NSRC-1:0]   src_req,
  input  logic [NSRC*4-1:0] src_lvl,
  input  logic [31:0]       status_in,
  input  logic [31:0]       pc_in,
  input  logic [31:0]       sp_in,
  input  logic              mask_wr_en,
  input  logic [3:0]        mask_wr_val,
  output logic              irq_req_n,
  output logic [3:0]        mask_lvl,
  output logic              busy,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              branch_valid,
  output logic [31:0]       branch_target,
  output logic [31:0]       sp_new
);
  localparam int IDW = $clog2(NSRC + 2);

  logic            nmi_pend, accept, win_valid, above;
  logic [NSRC-1:0] src_pend, src_clr;
  logic [4:0]      win_lvl;
  logic [IDW-1:0]  win_id;

  irq_src_capture #(.EDGE(1'b1)) u_nmi_cap (
    .clk(clk), .rst_n(rst_n), .req_in(nmi_in),
    .clr(accept && (win_id == '0)), .pend(nmi_pend));

  generate
    for (genvar k = 0; k < NSRC; k++) begin : g_src
      assign src_clr[k] = accept && (win_id == IDW'(k + 2));
      irq_src_capture #(.EDGE(EDGE_SRC[k])) u_cap (
        .clk(clk), .rst_n(rst_n), .req_in(src_req[k] && (src_lvl[k*4 +: 4] != 4'h0)),
        .clr(src_clr[k]), .pend(src_pend[k]));
    end
  endgenerate

  irq_prio_pick #(.NSRC(NSRC)) u_pick (
    .nmi_p(nmi_pend), .brk_p(brk_in), .src_p(src_pend), .src_lvl(src_lvl),
    .win_valid(win_valid), .win_lvl(win_lvl), .win_id(win_id));

  assign above     = win_valid && (win_lvl > {1'b0, mask_lvl});
  assign accept    = above && !busy;
  assign irq_req_n = !above;

  irq_entry_seq #(
    .NSRC(NSRC), .VEC_BASE(VEC_BASE), .VEC_NMI(VEC_NMI),
    .VEC_BRK(VEC_BRK), .VEC_SRC0(VEC_SRC0)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .win_id(win_id), .win_lvl(win_lvl),
    .status_in(status_in), .pc_in(pc_in), .sp_in(sp_in),
    .mask_wr_en(mask_wr_en), .mask_wr_val(mask_wr_val), .mask_q(mask_lvl), .busy(busy),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .branch_valid(branch_valid),
    .branch_target(branch_target), .sp_new(sp_new));

  // R5: a pending NMI always holds the request low
  p_nmi_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> !irq_req_n) else $error("p_nmi_unmasked_r5");
  // R9: nothing is taken while an entry is running
  p_no_take_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !branch_valid) |=> busy) else $error("p_no_take_busy_r9");
endmodule

// File: tb/irq_accept_ctrl_tb.sv
module irq_accept_ctrl_tb;
  localparam int NSRC = 4;
  logic clk = 0, rst_n = 0;
  logic nmi_in = 0, brk_in = 0, mask_wr_en = 0, mem_ready = 0;
  logic [NSRC-1:0] src_req = '0;
  logic [NSRC*4-1:0] src_lvl = '0;
  logic [31:0] status_in = 32'h1234_5670, pc_in = 32'h0000_4000, sp_in = 32'h0000_0100;
  logic [3:0] mask_wr_val = 4'h0;
  logic irq_req_n, busy, mem_valid, mem_we, branch_valid;
  logic [3:0] mask_lvl;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, branch_target, sp_new;

  int checks = 0, errors = 0, wn = 0, rdy_cnt = 0, bp_bad = 0, cyc = 0;
  logic [31:0] mem [0:63];
  logic [31:0] wlog_a [0:1023];
  logic [31:0] wlog_d [0:1023];
  logic prev_stall = 0;
  logic [31:0] prev_addr = 0;

  always #10 clk = ~clk;

  irq_accept_ctrl #(.NSRC(NSRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .brk_in(brk_in), .src_req(src_req),
    .src_lvl(src_lvl), .status_in(status_in), .pc_in(pc_in), .sp_in(sp_in),
    .mask_wr_en(mask_wr_en), .mask_wr_val(mask_wr_val), .irq_req_n(irq_req_n),
    .mask_lvl(mask_lvl), .busy(busy), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .branch_valid(branch_valid), .branch_target(branch_target), .sp_new(sp_new));

  assign mem_rdata = mem[mem_addr[7:2]];

  function automatic logic [31:0] vec_word(int v);
    return 32'hC0DE_0000 + 32'(v);
  endfunction

  always @(negedge clk) begin
    rdy_cnt <= rdy_cnt + 1;
    mem_ready <= ((rdy_cnt % 3) != 2);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_valid && mem_ready && mem_we) begin
      mem[mem_addr[7:2]] <= mem_wdata;
      wlog_a[wn] <= mem_addr;
      wlog_d[wn] <= mem_wdata;
      wn <= wn + 1;
    end
    if (prev_stall && (!mem_valid || mem_addr != prev_addr)) bp_bad <= bp_bad + 1;
    prev_stall <= mem_valid && !mem_ready;
    prev_addr  <= mem_addr;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic write_mask(input logic [3:0] m);
    @(negedge clk); mask_wr_val = m; mask_wr_en = 1;
    @(negedge clk); mask_wr_en = 0;
  endtask

  // waits for the branch strobe, then checks the whole entry (R6)
  task automatic run_entry(input int base, input int vec, input logic [3:0] lvl,
                           input logic [3:0] old_mask, input string tag);
    int n = 0;
    while (!branch_valid && n < 80) begin @(negedge clk); n++; end
    chk(branch_valid, {tag, " R9 branch seen"}, 32'(branch_valid), 1);
    chk(branch_target == vec_word(vec), {tag, " R6 target"}, branch_target, vec_word(vec));
    chk(mask_lvl == lvl, {tag, " R6 mask loaded"}, 32'(mask_lvl), 32'(lvl));
    chk(sp_new == sp_in - 8, {tag, " R6 sp_new"}, sp_new, sp_in - 8);
    chk(wn == base + 2, {tag, " R6 push count"}, 32'(wn), 32'(base + 2));
    chk(wlog_a[base] == sp_in - 4 && wlog_d[base] == {status_in[31:4], old_mask},
        {tag, " R6 status push"}, wlog_d[base], {status_in[31:4], old_mask});
    chk(wlog_a[base+1] == sp_in - 8 && wlog_d[base+1] == pc_in,
        {tag, " R6 pc push"}, wlog_d[base+1], pc_in);
  endtask

  initial begin
    int base;
    for (int i = 0; i < 64; i++) mem[i] = vec_word(i);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(irq_req_n == 1, "R1 irq_req_n", 32'(irq_req_n), 1);
    chk(busy == 0 && branch_valid == 0, "R1 busy/branch", 32'(busy), 0);
    chk(mask_lvl == 4'hF, "R1 mask", 32'(mask_lvl), 15);
    rst_n = 1;
    @(negedge clk);

    // R2 sweep every mask against every level on level source 2
    for (int m = 0; m < 16; m++) begin
      for (int l = 1; l < 16; l++) begin
        write_mask(4'(m));
        base = wn;
        src_lvl[11:8] = 4'(l); src_req[2] = 1;
        #1;
        chk(irq_req_n == !(l > m), "R2 request vs mask", 32'(irq_req_n), 32'(!(l > m)));
        if (l > m) begin
          run_entry(base, 18, 4'(l), 4'(m), "R2");
        end else begin
          @(negedge clk);
          chk(busy == 0, "R2 refused", 32'(busy), 0);
        end
        src_req[2] = 0;
        @(negedge clk);
      end
    end

    // R3 equal levels: lower index wins
    write_mask(0); base = wn;
    src_lvl = {4'd7, 4'd7, 4'd0, 4'd0}; src_req = 4'b1100;
    run_entry(base, 18, 4'd7, 4'd0, "R3 tie");
    src_req = 0; @(negedge clk);
    // R3 higher level wins over lower index
    write_mask(0); base = wn;
    src_lvl = {4'd8, 4'd7, 4'd0, 4'd0}; src_req = 4'b1100;
    run_entry(base, 19, 4'd8, 4'd0, "R3 level");
    src_req = 0; @(negedge clk);
    // R3 break beats a level-15 source
    write_mask(0); base = wn;
    src_lvl = {4'd15, 4'd0, 4'd0, 4'd0}; src_req = 4'b1000; brk_in = 1;
    run_entry(base, 12, 4'd15, 4'd0, "R3 brk");
    src_req = 0; brk_in = 0; @(negedge clk);
    // R3 NMI beats break
    write_mask(0); base = wn;
    nmi_in = 1; @(negedge clk); nmi_in = 0; brk_in = 1;
    run_entry(base, 11, 4'd15, 4'd0, "R3 nmi");
    brk_in = 0; @(negedge clk);

    // R4 break gated at mask 15, taken at mask 14
    write_mask(15);
    brk_in = 1; #1;
    chk(irq_req_n == 1, "R4 brk masked", 32'(irq_req_n), 1);
    @(negedge clk);
    chk(busy == 0, "R4 brk not taken", 32'(busy), 0);
    brk_in = 0;
    write_mask(14); base = wn;
    brk_in = 1;
    run_entry(base, 12, 4'd15, 4'd14, "R4");
    brk_in = 0; @(negedge clk);

    // R5 NMI under mask 15
    write_mask(15); base = wn;
    nmi_in = 1; @(negedge clk); nmi_in = 0;
    chk(irq_req_n == 0, "R5 nmi request", 32'(irq_req_n), 0);
    run_entry(base, 11, 4'd15, 4'd15, "R5");
    @(negedge clk);

    // R7 edge source latched while masked, taken when unmasked
    write_mask(15);
    src_lvl = {4'd0, 4'd0, 4'd0, 4'd6};
    src_req[0] = 1; @(negedge clk); src_req[0] = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && irq_req_n == 1, "R7 held masked", 32'(irq_req_n), 1);
    base = wn;
    @(negedge clk); mask_wr_val = 0; mask_wr_en = 1;
    @(negedge clk); mask_wr_en = 0;
    #1;
    chk(irq_req_n == 0, "R7 pending after unmask", 32'(irq_req_n), 0);
    @(negedge clk);
    // R8 released in the cycle after the edge source is taken
    chk(busy == 1 && irq_req_n == 1, "R8 release", 32'(irq_req_n), 1);
    run_entry(base, 16, 4'd6, 4'd0, "R7");
    write_mask(0);
    repeat (3) @(negedge clk);
    chk(busy == 0 && irq_req_n == 1, "R7 latch cleared", 32'(irq_req_n), 1);

    // R8 second pending source keeps the request low
    base = wn;
    src_lvl = {4'd0, 4'd0, 4'd5, 4'd9};
    src_req[1:0] = 2'b11; @(negedge clk); src_req[1:0] = 2'b00;
    chk(irq_req_n == 0, "R8 both latched", 32'(irq_req_n), 0);
    @(negedge clk);
    chk(busy == 1 && irq_req_n == 0, "R8 held low", 32'(irq_req_n), 0);
    run_entry(base, 16, 4'd9, 4'd0, "R8 first");
    @(negedge clk);
    chk(irq_req_n == 1 && busy == 0, "R8 lower level masked", 32'(irq_req_n), 1);
    write_mask(0); base = wn;
    run_entry(base, 17, 4'd5, 4'd0, "R8 second");
    @(negedge clk);

    // R9 NMI during an entry waits for the branch
    write_mask(0); base = wn;
    src_lvl = {4'd0, 4'd3, 4'd0, 4'd0}; src_req[2] = 1;
    @(negedge clk);
    src_req[2] = 0; nmi_in = 1;
    @(negedge clk); nmi_in = 0;
    chk(busy == 1, "R9 busy", 32'(busy), 1);
    run_entry(base, 18, 4'd3, 4'd0, "R9 first");
    @(negedge clk); base = wn;
    run_entry(base, 11, 4'd15, 4'd3, "R9 nmi after");
    @(negedge clk);

    // R11 level source removed while masked has no effect
    write_mask(15);
    src_lvl = {4'd10, 4'd0, 4'd0, 4'd0}; src_req[3] = 1;
    repeat (2) @(negedge clk);
    src_req[3] = 0;
    write_mask(0);
    repeat (3) @(negedge clk);
    chk(busy == 0 && irq_req_n == 1 && mask_lvl == 0, "R11 not latched", 32'(mask_lvl), 0);

    chk(bp_bad == 0, "R10 stalled request changed", 32'(bp_bad), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule